// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel samples. The data line, bit clock, left/right clock and word clock all come in without any timing relation to the fast system clock. Each one passes through a synchronizer, and the bit clock is watched for its sampling edge. A two-bit format select picks how each word is placed inside the half-frame: left-justified, left-justified one bit late, right-justified a fixed number of bit periods after the channel change, or started by a rising word clock. A polarity input chooses which bit-clock edge samples the data. The bit clock may stop between edges for any length of time.

Each received word is 4 to 16 bits long, MSB first, and set by a length input. The word is sign-extended to 16 bits and presented for one system cycle with a valid strobe and a channel flag. The block suits a front end that needs one sample bus for sources with different framings.

Top module: `serial_audio_rx`

## Requirements
- R1: During and after reset the output bus is zero and the valid strobe is low. No word is delivered until a frame start that follows reset: in formats 0 to 2 this is a change of the left/right level between two sampling edges, so the first sampling edge after reset never starts a word. In format 3 it is a rising word clock.
- R2: When `bclk_inv` is 0, data is sampled on rising bit-clock edges. When it is 1, data is sampled on falling edges.
- R3: `fmt_sel` = 0: the sampling edge at which a new left/right level is first seen carries the MSB.
- R4: `fmt_sel` = 1: the MSB is carried by the sampling edge one after the edge that first sees the new left/right level.
- R5: `fmt_sel` = 2: the MSB is carried by the 16th sampling edge after the edge that first sees the new left/right level.
- R6: `fmt_sel` = 3: the MSB is carried by the first sampling edge after a rising word clock, and changes of the left/right level start no word. In formats 0 to 2 the word clock has no effect.
- R7: `word_len` gives the number of bits kept per word. Values below 4 act as 4 and values above 16 act as 16. Bits after the last kept bit, up to the next frame start, are ignored.
- R8: `sample_out` holds the received word as a twos-complement number, sign-extended from its top received bit to 16 bits.
- R9: `sample_left` is 1 when the left/right clock was high at the MSB sampling edge (left channel) and 0 when it was low (right).
- R10: Each completed word raises `sample_valid` for exactly one system cycle. A frame start that arrives before a word completes drops that word.
- R11: Pauses in the bit clock of any length between edges leave the received words unchanged. The system clock must run at least four times the bit-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous, may be gated |
| lrclk_in | input | 1 | Left/right clock, asynchronous; high = left |
| wclk_in | input | 1 | Word clock, used only in format 3 |
| sdata_in | input | 1 | Serial data, MSB first |
| bclk_inv | input | 1 | 0 = sample on rising bit-clock edge, 1 = falling |
| fmt_sel | input | 2 | Framing: 0 LJ, 1 LJ delayed, 2 RJ offset 16, 3 word-clock |
| word_len | input | 5 | Bits per word, clamped to 4..16 |
| sample_out | output | 16 | Sign-extended received word |
| sample_valid | output | 1 | One-cycle strobe per word |
| sample_left | output | 1 | Channel of the word, 1 = left |

## Verification
The hardest situation to reach is a word being placed relative to an edge that the block sees only after the synchronizer delay. This matters most in the delayed and offset formats, where any error of one edge in the wait count shifts every bit. The bench drives a real stream and places junk bits on both sides of every word. It toggles the word clock in the formats that must ignore it and, in format 3, starts words away from the channel change. A word position that is off by one edge therefore changes the value the bench computes. Pauses in the bit clock, word lengths outside the legal range and both sampling polarities are swept across every format. Before the first real word after reset, the left/right level is driven high, so a design that counted the first edge as a transition would deliver an extra word.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      FMT_LJ     = 2'b00,
      FMT_LJ_DLY = 2'b01,
      FMT_RJ     = 2'b10,
      FMT_WCK    = 2'b11
   } fmt_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sar_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("sar_sync: WIDTH must be positive");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (rst) chain <= '0;
         else     chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/sar_edge.sv
module sar_edge (
   input  logic clk,
   input  logic rst,
   input  logic bclk_s,
   input  logic wclk_s,
   input  logic inv,
   output logic sample_evt,
   output logic wclk_rise
);
   logic bclk_d, wclk_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         bclk_d <= 1'b0;
         wclk_d <= 1'b0;
      end else begin
         bclk_d <= bclk_s;
         wclk_d <= wclk_s;
      end
   end

   always_comb begin
      if (inv) sample_evt = bclk_d & ~bclk_s;
      else     sample_evt = ~bclk_d & bclk_s;
   end
   assign wclk_rise = ~wclk_d & wclk_s;

   // R2/R11: a sampling edge needs the opposite edge between, so two never touch
   a_r2_event_spacing: assert property (@(posedge clk) disable iff (rst)
      sample_evt |=> !sample_evt);
endmodule

// File: rtl/sar_framer.sv
module sar_framer
   import sar_pkg::*;
#(
   parameter int RJ_OFFSET = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_evt,
   input  logic lr_s,
   input  logic wclk_rise,
   input  fmt_e fmt,
   output logic frame_start,
   output logic msb_now
);
   localparam int CW = $clog2(RJ_OFFSET + 1);

   if (RJ_OFFSET < 2) begin : g_bad_offset
      $error("sar_framer: RJ_OFFSET must be at least 2");
   end

   logic          lr_known, lr_last, wc_pend, wait_act;
   logic [CW-1:0] wcnt, delay;
   logic          wck_mode, lr_edge, start, wait_done;

   always_comb begin
      case (fmt)
         FMT_LJ_DLY: delay = CW'(1);
         FMT_RJ:     delay = CW'(RJ_OFFSET);
         default:    delay = '0;
      endcase
   end

   assign wck_mode  = (fmt == FMT_WCK);
   assign lr_edge   = sample_evt & lr_known & (lr_s != lr_last);
   assign start     = wck_mode ? (sample_evt & (wc_pend | wclk_rise)) : lr_edge;
   assign wait_done = sample_evt & wait_act & (wcnt == '0);
   assign msb_now   = start ? (delay == '0) : wait_done;
   assign frame_start = start;

   always_ff @(posedge clk) begin
      if (rst) begin
         lr_known <= 1'b0;
         lr_last  <= 1'b0;
         wc_pend  <= 1'b0;
         wait_act <= 1'b0;
         wcnt     <= '0;
      end else begin
         if (sample_evt) begin
            lr_known <= 1'b1;
            lr_last  <= lr_s;
         end
         wc_pend <= wck_mode & (wc_pend | wclk_rise) & ~sample_evt;
         if (start) begin
            wait_act <= (delay != '0);
            wcnt     <= (delay != '0) ? delay - CW'(1) : '0;
         end else if (sample_evt && wait_act) begin
            if (wcnt == '0) wait_act <= 1'b0;
            else            wcnt     <= wcnt - CW'(1);
         end
      end
   end

   // R3/R4/R5/R6: a word's MSB is only ever taken on a sampling edge
   a_r3_msb_on_edge: assert property (@(posedge clk) disable iff (rst)
      msb_now |-> sample_evt);
   // R5: the offset count never exceeds the programmed offset
   a_r5_wait_bound: assert property (@(posedge clk) disable iff (rst)
      wait_act |-> (wcnt < CW'(RJ_OFFSET)));
endmodule

// File: rtl/sar_deser.sv
module sar_deser #(
   parameter int MAX_W = 16,
   parameter int OUT_W = 16,
   localparam int LW   = $clog2(MAX_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_evt,
   input  logic             msb_now,
   input  logic             frame_start,
   input  logic             bit_in,
   input  logic             lr_s,
   input  logic [LW-1:0]    wlen,
   output logic [OUT_W-1:0] out_sample,
   output logic             out_valid,
   output logic             out_left
);
   if (OUT_W < MAX_W) begin : g_bad_out
      $error("sar_deser: OUT_W must be at least MAX_W");
   end

   logic [MAX_W-1:0] shreg, next_word;
   logic [LW-1:0]    cnt, next_cnt, out_wl;
   logic             active, chan, sgn;
   logic [OUT_W-1:0] wide, ext;

   assign next_word = {shreg[MAX_W-2:0], bit_in};
   assign next_cnt  = cnt + LW'(1);
   assign wide      = OUT_W'(next_word);
   assign sgn       = next_word[wlen - LW'(1)];

   always_comb begin
      for (int i = 0; i < OUT_W; i++) begin
         ext[i] = (i < int'(wlen)) ? wide[i] : sgn;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg      <= '0;
         cnt        <= '0;
         active     <= 1'b0;
         chan       <= 1'b0;
         out_sample <= '0;
         out_valid  <= 1'b0;
         out_left   <= 1'b0;
         out_wl     <= LW'(MAX_W);
      end else begin
         out_valid <= 1'b0;
         if (msb_now) begin
            shreg  <= MAX_W'(bit_in);
            cnt    <= LW'(1);
            active <= 1'b1;
            chan   <= lr_s;
         end else if (frame_start) begin
            active <= 1'b0;
         end else if (sample_evt && active) begin
            shreg <= next_word;
            cnt   <= next_cnt;
            if (next_cnt >= wlen) begin
               active     <= 1'b0;
               out_valid  <= 1'b1;
               out_sample <= ext;
               out_left   <= chan;
               out_wl     <= wlen;
            end
         end
      end
   end

   function automatic logic ext_ok(logic [OUT_W-1:0] v, logic [LW-1:0] wl);
      logic s;
      s = v[wl - LW'(1)];
      for (int i = 0; i < OUT_W; i++) begin
         if (i >= int'(wl) - 1 && v[i] != s) return 1'b0;
      end
      return 1'b1;
   endfunction

   // R10: the strobe is one cycle wide
   a_r10_one_cycle_valid: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
   // R8: every bit above the word's sign bit repeats it
   a_r8_sign_ext: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ext_ok(out_sample, out_wl));
   // R7: the bit count never runs past the widest word
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= LW'(MAX_W));
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int MAX_W       = 16,
   parameter int MIN_W       = 4,
   parameter int OUT_W       = 16,
   parameter int LEN_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int RJ_OFFSET   = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bclk_in,
   input  logic             lrclk_in,
   input  logic             wclk_in,
   input  logic             sdata_in,
   input  logic             bclk_inv,
   input  logic [1:0]       fmt_sel,
   input  logic [LEN_W-1:0] word_len,
   output logic [OUT_W-1:0] sample_out,
   output logic             sample_valid,
   output logic             sample_left
);
   localparam int LW = $clog2(MAX_W + 1);

   if (MIN_W < 2 || MIN_W > MAX_W) begin : g_bad_min
      $error("serial_audio_rx: MIN_W out of range");
   end
   if (LEN_W < LW) begin : g_bad_len
      $error("serial_audio_rx: LEN_W too narrow for MAX_W");
   end

   logic [3:0]    raw, syn;
   logic          bclk_s, lr_s, wclk_s, data_s;
   logic          sample_evt, wclk_rise, frame_start, msb_now;
   logic [LW-1:0] wl_eff;

   assign raw = {sdata_in, wclk_in, lrclk_in, bclk_in};

   sar_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst(rst), .d_async(raw), .q_sync(syn));

   assign {data_s, wclk_s, lr_s, bclk_s} = syn;

   always_comb begin
      if (word_len < LEN_W'(MIN_W))      wl_eff = LW'(MIN_W);
      else if (word_len > LEN_W'(MAX_W)) wl_eff = LW'(MAX_W);
      else                               wl_eff = LW'(word_len);
   end

   sar_edge i_edge (
      .clk(clk), .rst(rst), .bclk_s(bclk_s), .wclk_s(wclk_s), .inv(bclk_inv),
      .sample_evt(sample_evt), .wclk_rise(wclk_rise));

   sar_framer #(.RJ_OFFSET(RJ_OFFSET)) i_framer (
      .clk(clk), .rst(rst), .sample_evt(sample_evt), .lr_s(lr_s),
      .wclk_rise(wclk_rise), .fmt(fmt_e'(fmt_sel)),
      .frame_start(frame_start), .msb_now(msb_now));

   sar_deser #(.MAX_W(MAX_W), .OUT_W(OUT_W)) i_deser (
      .clk(clk), .rst(rst), .sample_evt(sample_evt), .msb_now(msb_now),
      .frame_start(frame_start), .bit_in(data_s), .lr_s(lr_s), .wlen(wl_eff),
      .out_sample(sample_out), .out_valid(sample_valid), .out_left(sample_left));

   // R10: a word completes only on the cycle after a sampling edge
   a_r10_valid_after_edge: assert property (@(posedge clk) disable iff (rst)
      sample_valid |-> $past(sample_evt));
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bclk_in = 1'b0, lrclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
   logic        bclk_inv = 1'b0;
   logic [1:0]  fmt_sel = 2'd0;
   logic [4:0]  word_len = 5'd16;
   logic [15:0] sample_out;
   logic        sample_valid, sample_left;

   always #2.5 clk = ~clk;

   serial_audio_rx i_serial_audio_rx (
      .clk(clk), .rst(rst), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
      .wclk_in(wclk_in), .sdata_in(sdata_in), .bclk_inv(bclk_inv),
      .fmt_sel(fmt_sel), .word_len(word_len), .sample_out(sample_out),
      .sample_valid(sample_valid), .sample_left(sample_left));

   int n_cmp = 0, n_bad = 0;
   logic [15:0] exp_val [512];
   logic        exp_left[512];
   string       exp_req [512];
   int wr_idx = 0, rd_idx = 0;
   bit done = 0;

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sext(input logic [15:0] val, input int wl);
      int m, v;
      m = 1 << wl;
      v = int'(val) % m;
      if (v >= m / 2) v = v - m;
      return 16'(v);
   endfunction

   function automatic int clampw(input int w);
      if (w < 4) return 4;
      if (w > 16) return 16;
      return w;
   endfunction

   // compare every delivered word with the next expected one
   always @(negedge clk) begin
      if (!rst && sample_valid && !done) begin
         if (rd_idx >= wr_idx) begin
            check(1'b0, "R1/R10 unexpected word", {15'd0, sample_left, sample_out}, 32'd0);
         end else begin
            check(sample_out == exp_val[rd_idx] && sample_left == exp_left[rd_idx],
                  exp_req[rd_idx], {15'd0, sample_left, sample_out},
                  {15'd0, exp_left[rd_idx], exp_val[rd_idx]});
            rd_idx++;
         end
      end
   end

   // one half-frame of 32 bit periods; wc_pos < 0 means no word clock pulse
   task automatic send_half(input int mode, input int wl, input logic [15:0] val,
                            input logic lr, input int wc_pos, input bit burst,
                            input bit push, input string req);
      int off;
      off = (mode == 1) ? 1 : (mode == 2) ? 16 : (mode == 3) ? wc_pos : 0;
      if (push) begin
         exp_val[wr_idx]  = sext(val, wl);
         exp_left[wr_idx] = lr;
         exp_req[wr_idx]  = req;
         wr_idx++;
      end
      for (int k = 0; k < 32; k++) begin
         int idx;
         idx = k - off;
         bclk_in  = bclk_inv;
         lrclk_in = lr;
         if (mode == 3) wclk_in = (k == wc_pos);
         else           wclk_in = (k % 4 == 1);
         if (push && idx >= 0 && idx < wl) sdata_in = val[wl - 1 - idx];
         else                              sdata_in = (k % 3 == 0);
         repeat (3) @(negedge clk);
         bclk_in = ~bclk_inv;
         repeat (3) @(negedge clk);
         if (burst && (k % 7 == 5)) repeat (9) @(negedge clk);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         check(1'b0, "watchdog", 32'd0, 32'd1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int wls[6] = '{4, 7, 12, 16, 2, 25};
      string mtag[4] = '{"R3", "R4", "R5", "R6"};
      repeat (5) @(negedge clk);
      check(sample_valid == 1'b0, "R1 valid in reset", {31'd0, sample_valid}, 32'd0);
      check(sample_out == 16'd0, "R1 sample in reset", {16'd0, sample_out}, 32'd0);
      rst = 1'b0;
      @(negedge clk);
      check(sample_valid == 1'b0 && sample_out == 16'd0, "R1 after reset",
            {15'd0, sample_valid, sample_out}, 32'd0);
      // first edge sees high LR: must not count as a transition (R1)
      fmt_sel = 2'd0; word_len = 5'd8;
      send_half(0, 8, 16'h0000, 1'b1, -1, 1'b0, 1'b0, "");
      send_half(0, 8, 16'h00A5, 1'b0, -1, 1'b0, 1'b1, "R1/R3 first word");
      for (int m = 0; m < 4; m++) begin
         for (int w = 0; w < 6; w++) begin
            for (int inv = 0; inv < 2; inv++) begin
               int cfg, wle;
               bit burst;
               string tag;
               cfg = m * 12 + w * 2 + inv;
               wle = clampw(wls[w]);
               burst = (w % 2 == 1);
               bclk_inv = inv[0];
               fmt_sel  = m[1:0];
               word_len = 5'(wls[w]);
               tag = $sformatf("%s/R7/R8/R9%s%s mode=%0d len=%0d", mtag[m],
                               inv ? "/R2" : "", burst ? "/R11" : "", m, wls[w]);
               send_half(m, wle, 16'h0, 1'b0, -1, burst, 1'b0, "");
               for (int f = 0; f < 2; f++) begin
                  logic [15:0] lv, rv;
                  lv = 16'(cfg * 16'h3A7 + f * 16'h1C9 + 16'h8001);
                  rv = 16'(cfg * 16'h2B5 + f * 16'h5F1 + 16'h4C3) ^ 16'hFFFF;
                  send_half(m, wle, lv, 1'b1, 0, burst, 1'b1, {tag, " left"});
                  send_half(m, wle, rv, 1'b0, 5, burst, 1'b1, {tag, " right"});
               end
            end
         end
      end
      repeat (20) @(negedge clk);
      check(rd_idx == wr_idx, "R10 word count", 32'(rd_idx), 32'(wr_idx));
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule